// File: doc/BRIEF.md
# Divider Setting Capture Port

This block holds the three settings that a frequency synthesizer's dividers need: a 9-bit feedback modulus M, a 2-bit output divide select N and a 3-bit select for a diagnostic output mux, T. With a 16 MHz reference cut down by 16 to 1 MHz, the synthesized output is M/N MHz. The feedback modulus is normally kept between 200 and 400. The settings come from one of two sources. The first is a parallel port that a board drives at power-up. The second is a three-wire serial port (clock, data, load strobe) that firmware uses later to retune the output.

Everything runs on one system clock. The serial clock, data and strobe, and the parallel load signal, are sampled as ordinary synchronous inputs. A rising serial clock is found by comparing the input with its value one cycle earlier. Each path's "transparent latch" behaviour is modelled as a register that reloads on every cycle while its path is open. When the path closes, the register keeps the last value it loaded. The parallel path always wins over the serial path. Opening the parallel path also clears T, because T can be written only through the serial stream.

Top module: `divcfg_port`

## Requirements
- R1: While `rst` is high at a clock edge, `cfg_m`, `cfg_n`, `cfg_t`, the shift register and `ser_dout` all become 0.
- R2: The 14-bit shift register moves one place, taking `ser_din` into bit 0, only on a clock edge where `ser_clk` is 1 and was 0 at the previous edge. Holding `ser_clk` high for many cycles gives exactly one shift.
- R3: After 14 shifts the register holds the stream with the first bit in bit 13. A serial load maps bits 13..11 to T (first bit is T's MSB), bits 10..9 to N (MSB first) and bits 8..0 to M (M8 first, M0 last).
- R4: While `par_load` is 1 and `ser_load` is 1, each edge copies the shift register fields into `cfg_t`/`cfg_n`/`cfg_m`. After `ser_load` returns to 0, they keep the value from the last edge at which it was 1.
- R5: While `par_load` is 0, each edge copies `par_m` and `par_n` into `cfg_m` and `cfg_n`. After `par_load` rises, they keep the values sampled at the last edge where it was 0.
- R6: While `par_load` is 0, `ser_load` has no effect and the outputs follow the parallel inputs.
- R7: Any edge with `par_load` at 0 sets `cfg_t` to 3'b000.
- R8: With `par_load` at 1 and `ser_load` at 0, `cfg_m`, `cfg_n` and `cfg_t` do not change, whatever `ser_clk` and `ser_din` do.
- R9: `ser_dout` is bit 13 of the shift register, so it shows the bit shifted in 14 serial-clock rises earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, sampled; a rise shifts once |
| ser_din | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial load strobe; high copies the shift register into the settings |
| par_load | input | 1 | Parallel load; low copies the parallel inputs and clears T, rising captures |
| par_m | input | 9 | Parallel feedback modulus |
| par_n | input | 2 | Parallel output divide select |
| cfg_m | output | 9 | Registered feedback modulus M |
| cfg_n | output | 2 | Registered output divide select N |
| cfg_t | output | 3 | Registered diagnostic select T |
| ser_dout | output | 1 | Most significant shift register bit, for chaining or readback |

## Verification
The shift assertions assume `ser_clk` is low while reset is held. This keeps the sampled-edge detector and the property's own edge view in step at the first cycle after reset, and the stimulus keeps the serial clock at 0 through every reset. The assertions also assume that every input changes only away from the active clock edge. The stimulus drives all inputs on the falling edge, and it holds each serial clock level for two system cycles so that every rise is seen as one clean edge.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  parameter int M_WIDTH = 9;
  parameter int N_WIDTH = 2;
  parameter int T_WIDTH = 3;

  // Which source updates the settings on this edge
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_PAR  = 2'd1,
    SRC_SER  = 2'd2
  } src_e;
endpackage

// File: rtl/divcfg_edge.sv
// Rising-edge detector for a sampled, slow control input
module divcfg_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig_in;
  end

  assign rise = sig_in & ~sig_q;
endmodule

// File: rtl/divcfg_shifter.sv
module divcfg_shifter #(
  parameter int SR_W = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_en,
  input  logic            din,
  output logic [SR_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {word[SR_W-2:0], din};
  end
endmodule

// File: rtl/divcfg_select.sv
module divcfg_select
  import divcfg_pkg::*;
#(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3,
  localparam int SR_W = M_W + N_W + T_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            par_load,
  input  logic            ser_load,
  input  logic [M_W-1:0]  par_m,
  input  logic [N_W-1:0]  par_n,
  input  logic [SR_W-1:0] sr_word,
  output logic [M_W-1:0]  cfg_m,
  output logic [N_W-1:0]  cfg_n,
  output logic [T_W-1:0]  cfg_t
);
  src_e src;

  // Parallel path wins; serial only when parallel is closed
  always_comb begin
    if (!par_load)     src = SRC_PAR;
    else if (ser_load) src = SRC_SER;
    else               src = SRC_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_m <= '0;
      cfg_n <= '0;
      cfg_t <= '0;
    end else begin
      case (src)
        SRC_PAR: begin
          cfg_m <= par_m;
          cfg_n <= par_n;
          cfg_t <= '0;
        end
        SRC_SER: begin
          cfg_t <= sr_word[SR_W-1 -: T_W];
          cfg_n <= sr_word[M_W +: N_W];
          cfg_m <= sr_word[M_W-1:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/divcfg_port.sv
module divcfg_port #(
  parameter int M_W = divcfg_pkg::M_WIDTH,
  parameter int N_W = divcfg_pkg::N_WIDTH,
  parameter int T_W = divcfg_pkg::T_WIDTH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ser_clk,
  input  logic           ser_din,
  input  logic           ser_load,
  input  logic           par_load,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  output logic [M_W-1:0] cfg_m,
  output logic [N_W-1:0] cfg_n,
  output logic [T_W-1:0] cfg_t,
  output logic           ser_dout
);
  localparam int SR_W = M_W + N_W + T_W;

  logic            sclk_rise;
  logic [SR_W-1:0] sr_q;

  divcfg_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_in (ser_clk),
    .rise   (sclk_rise)
  );

  divcfg_shifter #(.SR_W(SR_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (sclk_rise),
    .din      (ser_din),
    .word     (sr_q)
  );

  divcfg_select #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .par_load (par_load),
    .ser_load (ser_load),
    .par_m    (par_m),
    .par_n    (par_n),
    .sr_word  (sr_q),
    .cfg_m    (cfg_m),
    .cfg_n    (cfg_n),
    .cfg_t    (cfg_t)
  );

  assign ser_dout = sr_q[SR_W-1];
endmodule

// File: rtl/divcfg_checker.sv
module divcfg_checker #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3,
  localparam int SR_W = M_W + N_W + T_W
) (
  input logic            clk,
  input logic            rst,
  input logic            ser_clk,
  input logic            ser_din,
  input logic            ser_load,
  input logic            par_load,
  input logic [M_W-1:0]  par_m,
  input logic [N_W-1:0]  par_n,
  input logic [SR_W-1:0] sr_q,
  input logic [M_W-1:0]  cfg_m,
  input logic [N_W-1:0]  cfg_n,
  input logic [T_W-1:0]  cfg_t,
  input logic            ser_dout
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (cfg_m == '0 && cfg_n == '0 && cfg_t == '0 && sr_q == '0));

  assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |=> sr_q == {$past(sr_q[SR_W-2:0]), $past(ser_din)});

  assert_noshift_R2: assert property (@(posedge clk) disable iff (rst)
    !$rose(ser_clk) |=> $stable(sr_q));

  assert_serload_R4: assert property (@(posedge clk) disable iff (rst)
    (par_load && ser_load) |=> (cfg_m == $past(sr_q[M_W-1:0]) &&
                                cfg_t == $past(sr_q[SR_W-1 -: T_W])));

  assert_parload_R5: assert property (@(posedge clk) disable iff (rst)
    !par_load |=> (cfg_m == $past(par_m) && cfg_n == $past(par_n)));

  assert_tclear_R7: assert property (@(posedge clk) disable iff (rst)
    !par_load |=> cfg_t == '0);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (par_load && !ser_load) |=> ($stable(cfg_m) && $stable(cfg_n) && $stable(cfg_t)));

  assert_dout_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |=> ser_dout == $past(sr_q[SR_W-2]));
endmodule

bind divcfg_port divcfg_checker #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_chk (.*);

// File: tb/divcfg_port_tb.sv
module divcfg_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_clk = 1'b0, ser_din = 1'b0, ser_load = 1'b0, par_load = 1'b1;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic [8:0] cfg_m;
  logic [1:0] cfg_n;
  logic [2:0] cfg_t;
  logic       ser_dout;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  divcfg_port u_dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_load(ser_load), .par_load(par_load), .par_m(par_m), .par_n(par_n),
    .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t), .ser_dout(ser_dout)
  );

  // Serial stream words (first bit sent = bit 13) and expected fields
  localparam int NV = 6;
  localparam logic [13:0] VEC_WORD [NV] = '{
    14'b000_01_100000110, 14'b110_11_011001000, 14'b101_00_110010000,
    14'b111_10_100000000, 14'b001_00_000000001, 14'b010_11_111111111 };
  localparam int VEC_T [NV] = '{0, 6, 5, 7, 1, 2};
  localparam int VEC_N [NV] = '{1, 3, 0, 2, 0, 3};
  localparam int VEC_M [NV] = '{262, 200, 400, 256, 1, 511};

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic shift_bit(logic b);
    ser_din = b; ser_clk = 1'b1; tick(); tick();
    ser_clk = 1'b0; tick(); tick();
  endtask

  task automatic shift_word(logic [13:0] w);
    for (int i = 13; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic sload();
    ser_load = 1'b1; tick();
    ser_load = 1'b0; tick();
  endtask

  task automatic check_cfg(string req, int t, int n, int m);
    check(req, cfg_t, t);
    check(req, cfg_n, n);
    check(req, cfg_m, m);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0; tick();
    check_cfg("R1 reset", 0, 0, 0);
    check("R1 reset dout", ser_dout, 0);

    // Table walk: shift a word, load it serially (R3), check outputs
    for (int v = 0; v < NV; v++) begin
      shift_word(VEC_WORD[v]);
      check("R9 dout after word", ser_dout, VEC_WORD[v][13]);
      sload();
      check_cfg("R3 serial load", VEC_T[v], VEC_N[v], VEC_M[v]);
    end

    // R8: shifting with no load leaves settings untouched
    shift_word(14'b011_10_000000111);
    check_cfg("R8 hold", 2, 3, 511);
    check("R9 dout", ser_dout, 0);

    // R4: serial load open, follows the shift register
    ser_load = 1'b1; tick(); tick();
    check_cfg("R4 transparent", 3, 2, 7);
    shift_bit(1'b1);
    check_cfg("R4 follows shift", 7, 0, 15);
    ser_load = 1'b0; tick();
    shift_bit(1'b0);
    check_cfg("R4 held after close", 7, 0, 15);

    // R5 / R7: parallel path
    par_m = 9'd300; par_n = 2'd2; par_load = 1'b0; tick(); tick();
    check_cfg("R7 parallel clears T", 0, 2, 300);
    par_m = 9'd301; tick(); tick();
    check("R5 tracks while low", cfg_m, 301);
    par_load = 1'b1; par_m = 9'd399; par_n = 2'd3; tick(); tick();
    check_cfg("R5 capture on rise", 0, 2, 301);

    // R6: parallel beats serial
    par_m = 9'd222; par_n = 2'd1; par_load = 1'b0; ser_load = 1'b1; tick(); tick();
    check_cfg("R6 priority", 0, 1, 222);
    par_load = 1'b1; ser_load = 1'b0; tick(); tick();
    check_cfg("R6 after release", 0, 1, 222);

    // R2: long serial clock high gives one shift only
    ser_din = 1'b1; ser_clk = 1'b1;
    repeat (8) tick();
    ser_clk = 1'b0; tick(); tick();
    sload();
    check_cfg("R2 single shift", 4, 0, 61);
    check("R9 dout after single shift", ser_dout, 1);

    // R1: reset in mid-run
    rst = 1'b1; tick(); tick();
    rst = 1'b0; tick();
    check_cfg("R1 mid-run reset", 0, 0, 0);
    check("R1 mid-run dout", ser_dout, 0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule